// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Fast-Line Routing

This block gathers 64 peripheral request lines, split into two banks of 32, and presents them to a CPU as two active-high interrupt lines: a fast line and a normal line. A rising edge on a request line sets a pending bit. That bit stays set until software writes a one to it. Each source has an enable bit and a 3-bit priority. The priority also chooses the line that the source drives: levels 0 and 1 drive the fast line, and levels 2 to 7 drive the normal line. Level 0 is the most urgent and level 7 the least.

Software reaches the block through a 32-bit register bus with an 8-bit byte address. It can read pending status split by line, write ones to acknowledge requests, set enables, and program priorities. Priorities are packed eight to a word on a 4-bit stride. The block also gives the number of the most urgent enabled pending normal-line source, both on a port and in a read-only register. This saves software from scanning the pending words.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After synchronous reset, every pending and enable bit is 0, every priority is 7 (the word at 0x30 reads 0x77777777), both interrupt outputs are 0, and the top-source value is 0x7F.
- R2: A 0-to-1 change on `req[n]` sets the pending bit of source n at the next clock edge. A request held high does not set the bit again after it has been cleared.
- R3: Writing a 1 to bit j at 0x00 or 0x08 clears the pending bit of source j. Writing a 1 to bit j at 0x04 or 0x0C clears the pending bit of source 32+j. Zero bits leave their pending bits unchanged. A rising edge in the same cycle as a clear leaves the bit set.
- R4: The enable words at 0x18 (sources 0–31) and 0x1C (sources 32–63) read back as written. A cleared enable bit keeps its source away from both outputs and from the top-source value, but does not clear its pending bit.
- R5: The word at 0x30+4r holds the priorities of sources 8r to 8r+7. Source 8r+k uses bits [4k+2:4k]. Bit 4k+3 is ignored on write and reads as 0.
- R6: Reading 0x00 or 0x04 returns the pending bits of that bank's sources whose priority is 0 or 1. Reading 0x08 or 0x0C returns the pending bits of sources whose priority is 2 to 7. Enables do not affect either read.
- R7: `fast_irq` is high one cycle after some source is pending and enabled with priority 0 or 1. `norm_irq` is high one cycle after some source is pending and enabled with priority 2 to 7. Each output drops one cycle after its last such source is cleared, masked or moved to the other line.
- R8: `top_src`, and the word at 0x20, give the number of the enabled pending source with priority 2 to 7 that has the lowest priority value. When several sources share that value, the lowest source number is chosen. The value is 0x7F when no such source exists. It follows the register state with no added delay.
- R9: Offsets outside the map read as 0. Writes to them, and to 0x20, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 64 | Peripheral request lines, edge sensitive |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fast_irq | output | 1 | Fast interrupt line to the CPU |
| norm_irq | output | 1 | Normal interrupt line to the CPU |
| top_src | output | 7 | Most urgent enabled pending normal-line source, or 0x7F |

## Verification
A request edge or a register write changes the register state at the next rising edge. Read data and `top_src` show the new state at once, and the two interrupt outputs show it one rising edge later. The bench drives each step in the low phase of the clock. It advances its model at the rising edge, and computes the expected interrupt outputs from the state the model held before that edge. It samples at the following falling edge. Reads change only the address, so a few of them can be made within the same low phase without another clock edge passing.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int PRIO_W         = 3;
    localparam int PRIO_STRIDE    = 4;
    localparam int SLOTS_PER_WORD = 8;

    typedef logic [PRIO_W-1:0] prio_t;

    localparam prio_t PRIO_LOWEST  = prio_t'(7);
    localparam prio_t FAST_MAX_LVL = prio_t'(1);

    localparam logic [7:0] OFS_FAST_PEND = 8'h00;
    localparam logic [7:0] OFS_NORM_PEND = 8'h08;
    localparam logic [7:0] OFS_ENABLE    = 8'h18;
    localparam logic [7:0] OFS_TOP       = 8'h20;
    localparam logic [7:0] OFS_PRIO      = 8'h30;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_FAST,
        RG_NORM,
        RG_EN,
        RG_TOP,
        RG_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } reg_sel_t;

    function automatic logic goes_fast(prio_t p);
        return p <= FAST_MAX_LVL;
    endfunction

    function automatic reg_sel_t decode_addr(logic [7:0] a, int banks, int rows);
        reg_sel_t s;
        s.kind = RG_NONE;
        s.idx  = '0;
        for (int b = 0; b < banks; b++) begin
            if (a == 8'(OFS_FAST_PEND + 4 * b)) begin s.kind = RG_FAST; s.idx = 4'(b); end
            if (a == 8'(OFS_NORM_PEND + 4 * b)) begin s.kind = RG_NORM; s.idx = 4'(b); end
            if (a == 8'(OFS_ENABLE    + 4 * b)) begin s.kind = RG_EN;   s.idx = 4'(b); end
        end
        for (int r = 0; r < rows; r++) begin
            if (a == 8'(OFS_PRIO + 4 * r)) begin s.kind = RG_PRIO; s.idx = 4'(r); end
        end
        if (a == OFS_TOP) s.kind = RG_TOP;
        return s;
    endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] req,
    input  logic [BANK_W-1:0] clr,
    output logic [BANK_W-1:0] pend
);
    logic [BANK_W-1:0] req_q;
    logic [BANK_W-1:0] rise;

    assign rise = req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
        end else begin
            req_q <= req;
            pend  <= (pend & ~clr) | rise;
        end
    end

    // R2
    edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((pend & $past(rise)) == $past(rise)));

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~rise)) |=> ((pend & $past(clr & ~rise)) == '0));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

endmodule

// File: rtl/irq_prio_file.sv
module irq_prio_file
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ROW_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ROW_W-1:0]        wr_row,
    input  logic [31:0]             wr_data,
    output prio_t [NUM_SRC-1:0]     prio
);
    localparam int ROWS = NUM_SRC / SLOTS_PER_WORD;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) prio[i] <= PRIO_LOWEST;
        end else if (wr_en) begin
            for (int r = 0; r < ROWS; r++) begin
                if (wr_row == ROW_W'(r)) begin
                    for (int k = 0; k < SLOTS_PER_WORD; k++)
                        prio[r*SLOTS_PER_WORD + k] <= wr_data[PRIO_STRIDE*k +: PRIO_W];
                end
            end
        end
    end

    // R1
    reset_prio_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (prio == {NUM_SRC{PRIO_LOWEST}}));

    // R5
    prio_still_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(prio));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  cand,
    input  prio_t [NUM_SRC-1:0] prio,
    output logic                found,
    output logic [ID_W-1:0]     best_id
);
    localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

    prio_t best_p;

    always_comb begin
        found   = 1'b0;
        best_id = NONE_ID;
        best_p  = PRIO_LOWEST;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!found || prio[i] <= best_p)) begin
                found   = 1'b1;
                best_id = ID_W'(i);
                best_p  = prio[i];
            end
        end
    end

    // R8
    winner_valid_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> cand[best_id[ID_W-2:0]]);

    // R8
    none_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (best_id == NONE_ID) |-> (cand == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int BANK_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       req,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [BANK_W-1:0]        bus_wdata,
    output logic [BANK_W-1:0]        bus_rdata,
    output logic                     fast_irq,
    output logic                     norm_irq,
    output logic [$clog2(NUM_SRC):0] top_src
);
    localparam int NUM_BANKS = NUM_SRC / BANK_W;
    localparam int ROWS      = NUM_SRC / SLOTS_PER_WORD;
    localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int BK_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int ID_W      = SRC_W + 1;

    reg_sel_t             sel;
    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   en_q;
    logic [NUM_SRC-1:0]   fast_m;
    logic [NUM_SRC-1:0]   fast_cand;
    logic [NUM_SRC-1:0]   norm_cand;
    prio_t [NUM_SRC-1:0]  prio;
    logic                 found;
    logic [ID_W-1:0]      best_id;
    logic [NUM_BANKS-1:0][BANK_W-1:0] fast_view;
    logic [NUM_BANKS-1:0][BANK_W-1:0] norm_view;
    logic [NUM_BANKS-1:0][BANK_W-1:0] en_view;

    assign sel = decode_addr(8'(bus_addr), NUM_BANKS, ROWS);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] clr_b;
        assign clr_b = (bus_we && (sel.kind == RG_FAST || sel.kind == RG_NORM)
                        && sel.idx == 4'(b)) ? bus_wdata : '0;
        irq_bank #(.BANK_W(BANK_W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .req  (req[b*BANK_W +: BANK_W]),
            .clr  (clr_b),
            .pend (pend[b*BANK_W +: BANK_W])
        );
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
        assign fast_m[i] = goes_fast(prio[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (bus_we && sel.kind == RG_EN) begin
            for (int b = 0; b < NUM_BANKS; b++)
                if (sel.idx == 4'(b)) en_q[b*BANK_W +: BANK_W] <= bus_wdata;
        end
    end

    irq_prio_file #(.NUM_SRC(NUM_SRC), .ROW_W(ROW_W)) u_prio (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we && sel.kind == RG_PRIO),
        .wr_row  (sel.idx[ROW_W-1:0]),
        .wr_data (bus_wdata),
        .prio    (prio)
    );

    assign fast_cand = pend & en_q & fast_m;
    assign norm_cand = pend & en_q & ~fast_m;

    irq_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .cand    (norm_cand),
        .prio    (prio),
        .found   (found),
        .best_id (best_id)
    );

    assign top_src = best_id;

    always_ff @(posedge clk) begin
        if (rst) begin
            fast_irq <= 1'b0;
            norm_irq <= 1'b0;
        end else begin
            fast_irq <= |fast_cand;
            norm_irq <= |norm_cand;
        end
    end

    assign fast_view = pend & fast_m;
    assign norm_view = pend & ~fast_m;
    assign en_view   = en_q;

    always_comb begin
        bus_rdata = '0;
        unique case (sel.kind)
            RG_FAST: bus_rdata = fast_view[sel.idx[BK_W-1:0]];
            RG_NORM: bus_rdata = norm_view[sel.idx[BK_W-1:0]];
            RG_EN:   bus_rdata = en_view[sel.idx[BK_W-1:0]];
            RG_TOP:  bus_rdata = BANK_W'(best_id);
            RG_PRIO: begin
                for (int k = 0; k < SLOTS_PER_WORD; k++)
                    bus_rdata[PRIO_STRIDE*k +: PRIO_W] =
                        prio[SRC_W'(int'(sel.idx[ROW_W-1:0]) * SLOTS_PER_WORD + k)];
            end
            default: bus_rdata = '0;
        endcase
    end

    // R7
    fast_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|fast_cand) |=> fast_irq);

    // R7
    fast_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !(|fast_cand) |=> !fast_irq);

    // R7
    norm_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|norm_cand) |=> norm_irq);

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend & en_q) == '0) |=> (!fast_irq && !norm_irq));

    // R8
    top_none_chk: assert property (@(posedge clk) disable iff (rst)
        !found |-> (top_src == {ID_W{1'b1}}));

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] req = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_irq, norm_irq;
    logic [6:0]  top_src;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [63:0] m_pend = '0, m_en = '0, m_prev = '0;
    logic [2:0]  m_prio [64];
    logic        e_fast = 0, e_norm = 0;

    prio_irq_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fast_irq(fast_irq),
        .norm_irq(norm_irq), .top_src(top_src)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] fmask();
        logic [63:0] m;
        for (int i = 0; i < 64; i++) m[i] = (m_prio[i] <= 3'd1);
        return m;
    endfunction

    function automatic logic [6:0] exp_top();
        logic [6:0] best = 7'h7F;
        logic [2:0] bp = 3'd7;
        logic [63:0] fm = fmask();
        for (int i = 63; i >= 0; i--)
            if (m_pend[i] && m_en[i] && !fm[i] && (best == 7'h7F || m_prio[i] <= bp)) begin
                best = 7'(i);
                bp = m_prio[i];
            end
        return best;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [63:0] fm = fmask();
        logic [31:0] w = '0;
        case (a)
            8'h00: w = m_pend[31:0] & fm[31:0];
            8'h04: w = m_pend[63:32] & fm[63:32];
            8'h08: w = m_pend[31:0] & ~fm[31:0];
            8'h0C: w = m_pend[63:32] & ~fm[63:32];
            8'h18: w = m_en[31:0];
            8'h1C: w = m_en[63:32];
            8'h20: w = {25'd0, exp_top()};
            default:
                if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
                    for (int k = 0; k < 8; k++) w[4*k +: 3] = m_prio[(a - 8'h30) * 2 + k];
        endcase
        return w;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [63:0] r, logic w, logic [7:0] a, logic [31:0] d);
        logic [63:0] clr = '0;
        logic [63:0] fm;
        req = r; bus_we = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        fm = fmask();
        e_fast = |(m_pend & m_en & fm);
        e_norm = |(m_pend & m_en & ~fm);
        if (w) begin
            case (a)
                8'h00, 8'h08: clr[31:0] = d;
                8'h04, 8'h0C: clr[63:32] = d;
                8'h18: m_en[31:0] = d;
                8'h1C: m_en[63:32] = d;
                default:
                    if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
                        for (int k = 0; k < 8; k++) m_prio[(a - 8'h30) * 2 + k] = d[4*k +: 3];
            endcase
        end
        m_pend = (m_pend & ~clr) | (r & ~m_prev);
        m_prev = r;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle();
        cyc(req, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic rd(string tag, logic [7:0] a);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp_read(a)));
    endtask

    task automatic outs(string tag);
        chk({tag, " fast_irq"}, 64'(fast_irq), 64'(e_fast));
        chk({tag, " norm_irq"}, 64'(norm_irq), 64'(e_norm));
        chk({tag, " top_src"}, 64'(top_src), 64'(exp_top()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [7:0] addrs [15];
        seed = $urandom(32'h5EED1234);
        for (int i = 0; i < 64; i++) m_prio[i] = 3'd7;
        for (int i = 0; i < 8; i++) addrs[i] = 8'h30 + 8'(4 * i);
        addrs[8] = 8'h00; addrs[9] = 8'h04; addrs[10] = 8'h08; addrs[11] = 8'h0C;
        addrs[12] = 8'h18; addrs[13] = 8'h1C; addrs[14] = 8'h24;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 fast_irq", 64'(fast_irq), 64'd0);
        chk("R1 norm_irq", 64'(norm_irq), 64'd0);
        chk("R1 top_src", 64'(top_src), 64'h7F);
        bus_addr = 8'h30; #1 chk("R1 prio word", 64'(bus_rdata), 64'h77777777);
        bus_addr = 8'h1C; #1 chk("R1 enable word", 64'(bus_rdata), 64'h0);

        cyc('0, 1, 8'h18, 32'hFFFF_FFFF);
        cyc('0, 1, 8'h1C, 32'hFFFF_FFFF);
        rd("R4 enable readback", 8'h1C);

        // R2 edge latch on source 5
        cyc(64'h20, 0, 8'h00, 0);
        chk("R2 pend normal bank0", 64'(bus_rdata), 64'h0);
        rd("R2 pend normal bank0", 8'h08);
        chk("R8 top follows at once", 64'(top_src), 64'd5);
        outs("R7 not yet");
        idle();
        chk("R7 norm_irq rises", 64'(norm_irq), 64'd1);
        outs("R7");

        // R3 clear, held level does not re-trigger
        cyc(64'h20, 1, 8'h08, 32'h20);
        rd("R3 cleared", 8'h08);
        idle();
        chk("R7 norm_irq drops", 64'(norm_irq), 64'd0);
        rd("R2 held level no retrigger", 8'h08);

        // R3 edge beats clear in the same cycle
        cyc('0, 0, 8'h00, 0);
        cyc(64'h20, 1, 8'h08, 32'h20);
        bus_addr = 8'h08; #1 chk("R3 edge wins", 64'(bus_rdata), 64'h20);

        // R5 layout, R6 routing
        cyc(64'h20, 1, 8'h30, 32'hFFFF_FFF9);
        bus_addr = 8'h30; #1 chk("R5 packed word", 64'(bus_rdata), 64'h77777771);
        cyc(64'h21, 0, 8'h00, 0);
        bus_addr = 8'h00; #1 chk("R6 fast pend", 64'(bus_rdata), 64'h1);
        rd("R6 normal pend", 8'h08);
        idle();
        chk("R7 fast_irq", 64'(fast_irq), 64'd1);
        outs("R7 both");

        // R4 mask keeps pending
        cyc(req, 1, 8'h18, 32'h0);
        idle();
        chk("R4 masked fast", 64'(fast_irq), 64'd0);
        chk("R4 masked top", 64'(top_src), 64'h7F);
        rd("R4 pending kept", 8'h00);
        cyc(req, 1, 8'h18, 32'hFFFF_FFFF);
        idle();
        chk("R4 unmask restores", 64'(fast_irq), 64'd1);

        // R8 ties and ordering
        cyc(req, 1, 8'h00, 32'hFFFF_FFFF);
        cyc('0, 1, 8'h04, 32'hFFFF_FFFF);
        cyc('0, 1, 8'h44, 32'h0000_0033);
        cyc((64'h1 << 40) | (64'h1 << 41) | (64'h1 << 42) | 64'h20, 0, 8'h00, 0);
        chk("R8 tie lowest number", 64'(top_src), 64'd40);
        rd("R8 top register", 8'h20);
        cyc(req, 1, 8'h04, 32'h100);
        chk("R8 next after clear", 64'(top_src), 64'd41);
        cyc(req, 1, 8'h0C, 32'h200);
        chk("R8 falls to prio 7", 64'(top_src), 64'd5);
        outs("R8");

        // R9 unmapped and read-only
        cyc(req, 1, 8'h24, 32'hFFFF_FFFF);
        cyc(req, 1, 8'h20, 32'h0);
        bus_addr = 8'h24; #1 chk("R9 unmapped reads 0", 64'(bus_rdata), 64'h0);
        rd("R9 enables untouched", 8'h18);
        rd("R9 prio untouched", 8'h44);

        // random phase
        for (int n = 0; n < 600; n++) begin
            logic [63:0] flip = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            logic w = ($urandom % 3) == 0;
            logic [7:0] a = addrs[$urandom % 15];
            logic [31:0] d = $urandom;
            if (a == 8'h18 || a == 8'h1C) d = d | $urandom;
            cyc(req ^ flip, w, a, d);
            outs("R7/R8 random");
            rd("R3/R6 random read", addrs[$urandom % 15]);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule